// File: doc/BRIEF.md
# Rectangle fill engine

This block paints a solid, axis-aligned rectangle into a linear pixel memory. Software programs it through a small register write bus: a drawing-operation code, a 32-bit foreground colour, a raster-operation code, and the rectangle's top row, left column, height and width. Writing the width register launches the fill. The engine then visits every pixel of the rectangle and issues one memory request per access on a valid/ready pixel port.

Each pixel is handled according to the raster operation chosen at launch. In replace mode the engine issues one write carrying the colour. In XOR mode it first reads the pixel, waits for the returned data, and then writes the colour XOR the old value back to the same address. In keep mode nothing in memory changes. The `busy` output is high from launch until the last pixel write has been accepted.

Pixels are addressed as row times a fixed pitch of 2048 pixels plus column. Colour and raster-operation settings persist between fills, so a driver rewrites them only when they change.

Top module: `rectfill_engine`

## Requirements
- R1: After reset `busy` and `mem_req_valid` are low, the operation register holds 0x00 and the raster-op register holds 0x83.
- R2: Register indices are: 0 operation, 1 colour, 2 raster op, 3 top row, 4 left column, 5 height, 6 width. A write to index 6 while idle launches a fill when the operation register holds 0x08, the height register and the written width are both non-zero, and the raster op is 0x83 or 0x86. `busy` is high on the cycle after that write.
- R3: A width write while the operation register holds any code other than 0x08 (for example 0x0A) is ignored. `busy` stays low and no memory request is made.
- R4: Pixels are visited row-major. The column runs from left to left+width-1 within a row, and rows run from top to top+height-1. Each pixel's address is row*2048 + column.
- R5: Raster op 0x83 (replace) writes the 32-bit colour unchanged to every pixel and makes no read request. The colour word packs blue in bits 23:16, green in 15:8 and red in 7:0.
- R6: Raster op 0x86 (XOR) reads each pixel, waits for `mem_rd_valid`, then writes colour XOR read data to the same address.
- R7: Any other raster-op code, including 0x85 (keep), leaves memory unchanged. The width write makes no request and `busy` stays low.
- R8: A height or width of zero makes no memory request, and `busy` stays low.
- R9: Colour and raster-op registers keep their values across fills. A fill launched with only geometry rewritten uses the previously written colour and raster op.
- R10: `busy` stays high until the final write is accepted and falls on the next cycle. A width write while busy neither restarts nor lengthens the fill.
- R11: While `mem_req_valid` is high and `mem_req_ready` is low, the request's address, direction and data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| mem_req_valid | output | 1 | Pixel request valid |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 22 | Pixel address |
| mem_req_wdata | output | 32 | Pixel write data |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | 32 | Read data |
| busy | output | 1 | Fill in progress |

## Verification
The hardest case to reach is an XOR fill where the memory withholds `mem_req_ready` on some requests and returns read data several cycles late. In that case the captured old value, the held request and the row wrap all interact. The bench's memory model stalls ready on a repeating cycle pattern and returns read data two cycles after each accepted read. It preloads address-dependent values, so every written word can be predicted. A width rewrite issued mid-fill under the same stalls covers the restart case.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam logic [7:0] OP_RECT     = 8'h08;
  localparam logic [7:0] ROP_REPLACE = 8'h83;
  localparam logic [7:0] ROP_KEEP    = 8'h85;
  localparam logic [7:0] ROP_XOR     = 8'h86;

  typedef enum logic [2:0] {
    RA_OPCODE = 3'd0,
    RA_COLOUR = 3'd1,
    RA_ROP    = 3'd2,
    RA_TOP    = 3'd3,
    RA_LEFT   = 3'd4,
    RA_HEIGHT = 3'd5,
    RA_WIDTH  = 3'd6
  } reg_idx_e;

  typedef enum logic [1:0] {
    RM_KEEP    = 2'd0,
    RM_REPLACE = 2'd1,
    RM_XOR     = 2'd2
  } rop_mode_e;

  typedef enum logic [1:0] {
    S_IDLE    = 2'd0,
    S_RD_REQ  = 2'd1,
    S_RD_WAIT = 2'd2,
    S_WR_REQ  = 2'd3
  } fill_state_e;
endpackage

// File: rtl/rf_regs.sv
module rf_regs
  import rf_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int COORD_W = 11,
  parameter int DIM_W   = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [2:0]         addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [7:0]         op_code,
  output logic [DATA_W-1:0]  colour,
  output logic [7:0]         rop_code,
  output logic [COORD_W-1:0] top_y,
  output logic [COORD_W-1:0] left_x,
  output logic [DIM_W-1:0]   height,
  output logic               start,
  output logic [DIM_W-1:0]   start_width
);
  logic unused_hi_bits;
  assign unused_hi_bits = ^wdata[DATA_W-1:DIM_W];

  assign start       = we && (addr == RA_WIDTH);
  assign start_width = wdata[DIM_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      op_code  <= '0;
      colour   <= '0;
      rop_code <= ROP_REPLACE;
      top_y    <= '0;
      left_x   <= '0;
      height   <= '0;
    end else if (we) begin
      case (addr)
        RA_OPCODE: op_code  <= wdata[7:0];
        RA_COLOUR: colour   <= wdata;
        RA_ROP:    rop_code <= wdata[7:0];
        RA_TOP:    top_y    <= wdata[COORD_W-1:0];
        RA_LEFT:   left_x   <= wdata[COORD_W-1:0];
        RA_HEIGHT: height   <= wdata[DIM_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rf_scan.sv
module rf_scan #(
  parameter int COORD_W = 11,
  parameter int DIM_W   = 12,
  parameter int PITCH   = 2048,
  parameter int ADDR_W  = 22
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic               step,
  input  logic [COORD_W-1:0] top_y,
  input  logic [COORD_W-1:0] left_x,
  input  logic [DIM_W-1:0]   height,
  input  logic [DIM_W-1:0]   width,
  output logic [ADDR_W-1:0]  pix_addr,
  output logic               last
);
  logic [COORD_W-1:0] x_q, y_q, left_q;
  logic [DIM_W-1:0]   col_q, row_q, w_q, h_q;
  logic               row_end;

  assign row_end  = (col_q == w_q - 1'b1);
  assign last     = row_end && (row_q == h_q - 1'b1);
  assign pix_addr = ADDR_W'(y_q) * ADDR_W'(PITCH) + ADDR_W'(x_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      x_q <= '0; y_q <= '0; left_q <= '0;
      col_q <= '0; row_q <= '0; w_q <= '0; h_q <= '0;
    end else if (load) begin
      x_q <= left_x; y_q <= top_y; left_q <= left_x;
      col_q <= '0; row_q <= '0; w_q <= width; h_q <= height;
    end else if (step) begin
      if (row_end) begin
        col_q <= '0;
        x_q   <= left_q;
        row_q <= row_q + 1'b1;
        y_q   <= y_q + 1'b1;
      end else begin
        col_q <= col_q + 1'b1;
        x_q   <= x_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rf_rop_alu.sv
module rf_rop_alu
  import rf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [7:0]        rop_code,
  input  rop_mode_e         mode_sel,
  input  logic [DATA_W-1:0] fg,
  input  logic [DATA_W-1:0] old_pix,
  output rop_mode_e         mode_dec,
  output logic [DATA_W-1:0] result
);
  always_comb begin
    case (rop_code)
      ROP_REPLACE: mode_dec = RM_REPLACE;
      ROP_XOR:     mode_dec = RM_XOR;
      default:     mode_dec = RM_KEEP;
    endcase
  end

  assign result = (mode_sel == RM_XOR) ? (fg ^ old_pix) : fg;
endmodule

// File: rtl/rectfill_engine.sv
module rectfill_engine
  import rf_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int COORD_W = 11,
  parameter int PITCH   = 2048,
  localparam int DIM_W  = COORD_W + 1,
  localparam int ADDR_W = COORD_W + $clog2(PITCH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rd_valid,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              busy
);
  logic [7:0]         op_code, rop_code;
  logic [DATA_W-1:0]  colour, fg_q, wdata_q, alu_result;
  logic [COORD_W-1:0] top_y, left_x;
  logic [DIM_W-1:0]   height_r, start_width;
  logic               start, go, step, last, mode_xor;
  rop_mode_e          mode_dec, mode_q;
  fill_state_e        state_q;

  rf_regs #(.DATA_W(DATA_W), .COORD_W(COORD_W), .DIM_W(DIM_W)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .op_code(op_code), .colour(colour), .rop_code(rop_code),
    .top_y(top_y), .left_x(left_x), .height(height_r),
    .start(start), .start_width(start_width)
  );

  rf_scan #(.COORD_W(COORD_W), .DIM_W(DIM_W), .PITCH(PITCH), .ADDR_W(ADDR_W)) u_scan (
    .clk(clk), .rst(rst), .load(go), .step(step),
    .top_y(top_y), .left_x(left_x), .height(height_r), .width(start_width),
    .pix_addr(mem_req_addr), .last(last)
  );

  rf_rop_alu #(.DATA_W(DATA_W)) u_alu (
    .rop_code(rop_code), .mode_sel(mode_q), .fg(fg_q), .old_pix(mem_rd_data),
    .mode_dec(mode_dec), .result(alu_result)
  );

  assign go = start && (state_q == S_IDLE) && (op_code == OP_RECT) &&
              (height_r != '0) && (start_width != '0) && (mode_dec != RM_KEEP);
  assign step = (state_q == S_WR_REQ) && mem_req_ready && !last;

  assign mem_req_valid = (state_q == S_RD_REQ) || (state_q == S_WR_REQ);
  assign mem_req_write = (state_q == S_WR_REQ);
  assign mem_req_wdata = wdata_q;
  assign busy          = (state_q != S_IDLE);
  assign mode_xor      = (mode_q == RM_XOR);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      mode_q  <= RM_REPLACE;
      fg_q    <= '0;
      wdata_q <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (go) begin
          fg_q    <= colour;
          wdata_q <= colour;
          mode_q  <= mode_dec;
          state_q <= (mode_dec == RM_XOR) ? S_RD_REQ : S_WR_REQ;
        end
        S_RD_REQ: if (mem_req_ready) state_q <= S_RD_WAIT;
        S_RD_WAIT: if (mem_rd_valid) begin
          wdata_q <= alu_result;
          state_q <= S_WR_REQ;
        end
        S_WR_REQ: if (mem_req_ready) begin
          if (last) state_q <= S_IDLE;
          else      state_q <= mode_xor ? S_RD_REQ : S_WR_REQ;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rf_checker.sv
module rf_checker
  import rf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DIM_W  = 12,
  parameter int ADDR_W = 22
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_we,
  input logic [2:0]        reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_write,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [DATA_W-1:0] mem_req_wdata,
  input logic              busy,
  input logic [7:0]        op_code,
  input logic [7:0]        rop_code,
  input logic [DIM_W-1:0]  height_r,
  input logic              mode_xor
);
  logic [ADDR_W-1:0] rd_addr_q;
  logic              width_wr;

  assign width_wr = reg_we && (reg_addr == RA_WIDTH) && !busy;

  always_ff @(posedge clk) begin
    if (rst) rd_addr_q <= '0;
    else if (mem_req_valid && mem_req_ready && !mem_req_write) rd_addr_q <= mem_req_addr;
  end

  p_start_r2: assert property (@(posedge clk) disable iff (rst)
    width_wr && op_code == OP_RECT && height_r != '0 && reg_wdata[DIM_W-1:0] != '0 &&
    (rop_code == ROP_REPLACE || rop_code == ROP_XOR) |=> busy);

  p_badop_r3: assert property (@(posedge clk) disable iff (rst)
    width_wr && op_code != OP_RECT |=> !busy && !mem_req_valid);

  p_noread_r5: assert property (@(posedge clk) disable iff (rst)
    busy && !mode_xor && mem_req_valid |-> mem_req_write);

  p_same_addr_r6: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && mem_req_write && mode_xor |-> mem_req_addr == rd_addr_q);

  p_keep_r7: assert property (@(posedge clk) disable iff (rst)
    width_wr && rop_code != ROP_REPLACE && rop_code != ROP_XOR |=> !busy);

  p_zero_r8: assert property (@(posedge clk) disable iff (rst)
    width_wr && (height_r == '0 || reg_wdata[DIM_W-1:0] == '0) |=> !busy);

  p_valid_busy_r10: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> busy);

  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) &&
    $stable(mem_req_write) && $stable(mem_req_wdata));
endmodule

bind rectfill_engine rf_checker #(.DATA_W(DATA_W), .DIM_W(DIM_W), .ADDR_W(ADDR_W)) u_checker (
  .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
  .mem_req_wdata(mem_req_wdata), .busy(busy), .op_code(op_code),
  .rop_code(rop_code), .height_r(height_r), .mode_xor(mode_xor)
);

// File: tb/rectfill_engine_test.sv
module rectfill_engine_test;
  logic        clk = 0;
  logic        rst = 1;
  logic        reg_we = 0;
  logic [2:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic        mem_req_valid, mem_req_write, busy;
  logic        mem_req_ready = 1;
  logic [21:0] mem_req_addr;
  logic [31:0] mem_req_wdata;
  logic        mem_rd_valid = 0;
  logic [31:0] mem_rd_data = 0;

  always #2.5 clk = ~clk;

  rectfill_engine uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rd_valid(mem_rd_valid),
    .mem_rd_data(mem_rd_data), .busy(busy)
  );

  int n_chk = 0, n_fail = 0;
  logic [31:0] mem [int unsigned];
  int unsigned wr_addr [64];
  logic [31:0] wr_data [64];
  int wr_n = 0, rd_n = 0, rd_cnt = 0;
  logic [31:0] rd_buf = 0;
  bit stall = 0;
  int cyc = 0;

  // memory model: ready pattern, 2-cycle read latency
  always @(posedge clk) begin
    cyc++;
    mem_rd_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      if (mem_req_write) begin
        mem[int'(mem_req_addr)] = mem_req_wdata;
        if (wr_n < 64) begin
          wr_addr[wr_n] = int'(mem_req_addr);
          wr_data[wr_n] = mem_req_wdata;
        end
        wr_n++;
      end else begin
        rd_buf = mem.exists(int'(mem_req_addr)) ? mem[int'(mem_req_addr)] : 32'h0;
        rd_cnt = 2;
        rd_n++;
      end
    end else if (rd_cnt == 1) begin
      mem_rd_valid <= 1'b1;
      mem_rd_data  <= rd_buf;
      rd_cnt = 0;
    end else if (rd_cnt > 1) begin
      rd_cnt--;
    end
    mem_req_ready <= stall ? ((cyc % 3) != 0) : 1'b1;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 2000) begin @(negedge clk); n++; end
    chk(!busy, "R10 busy falls", busy, 0);
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [31:0] seed(int unsigned a);
    return (a * 32'h01010101) ^ 32'hA5A5A5A5;
  endfunction

  task automatic clear_log();
    wr_n = 0; rd_n = 0;
  endtask

  task automatic geom(input int top, input int left, input int h);
    wr(3'd3, top); wr(3'd4, left); wr(3'd5, h);
  endtask

  task automatic verify(input string req, input int top, input int left, input int h, input int w,
                        input bit xr, input logic [31:0] fg);
    int k = 0;
    chk(wr_n == h * w, {req, " write count"}, wr_n, h * w);
    chk(rd_n == (xr ? h * w : 0), {req, " read count"}, rd_n, xr ? h * w : 0);
    for (int y = top; y < top + h; y++)
      for (int x = left; x < left + w; x++) begin
        int unsigned a = y * 2048 + x;
        logic [31:0] e = xr ? (fg ^ seed(a)) : fg;
        chk(wr_addr[k] == a, {"R4 order ", req}, wr_addr[k], a);
        chk(wr_data[k] == e, {req, " data"}, wr_data[k], e);
        k++;
      end
  endtask

  task automatic t_reset();
    chk(busy == 0, "R1 busy", busy, 0);
    chk(mem_req_valid == 0, "R1 valid", mem_req_valid, 0);
  endtask

  task automatic t_replace();
    clear_log();
    wr(3'd0, 32'h08); wr(3'd1, 32'h00123456); wr(3'd2, 32'h83);
    geom(3, 5, 2);
    wr(3'd6, 3);
    chk(busy == 1, "R2 start", busy, 1);
    wait_idle();
    verify("R5", 3, 5, 2, 3, 0, 32'h00123456);
  endtask

  task automatic t_badop();
    clear_log();
    wr(3'd0, 32'h0A);
    geom(0, 0, 2);
    wr(3'd6, 2);
    chk(busy == 0, "R3 busy", busy, 0);
    repeat (6) @(negedge clk);
    chk(wr_n + rd_n == 0, "R3 accesses", wr_n + rd_n, 0);
    wr(3'd0, 32'h08);
  endtask

  task automatic t_zero();
    clear_log();
    geom(1, 1, 0);
    wr(3'd6, 4);
    chk(busy == 0, "R8 height0 busy", busy, 0);
    geom(1, 1, 3);
    wr(3'd6, 0);
    chk(busy == 0, "R8 width0 busy", busy, 0);
    repeat (6) @(negedge clk);
    chk(wr_n + rd_n == 0, "R8 accesses", wr_n + rd_n, 0);
  endtask

  task automatic t_retain();
    clear_log();
    geom(7, 2040, 2);
    wr(3'd6, 2);
    wait_idle();
    verify("R9", 7, 2040, 2, 2, 0, 32'h00123456);
  endtask

  task automatic t_xor();
    for (int y = 10; y < 12; y++)
      for (int x = 4; x < 7; x++) mem[y * 2048 + x] = seed(y * 2048 + x);
    clear_log();
    stall = 1;
    wr(3'd1, 32'h00FF0F0F); wr(3'd2, 32'h86);
    geom(10, 4, 2);
    wr(3'd6, 3);
    chk(busy == 1, "R2 xor start", busy, 1);
    wait_idle();
    stall = 0;
    verify("R6 R11", 10, 4, 2, 3, 1, 32'h00FF0F0F);
  endtask

  task automatic t_keep();
    clear_log();
    wr(3'd2, 32'h85);
    geom(10, 4, 2);
    wr(3'd6, 3);
    chk(busy == 0, "R7 busy", busy, 0);
    repeat (6) @(negedge clk);
    chk(wr_n + rd_n == 0, "R7 accesses", wr_n + rd_n, 0);
    chk(mem[10 * 2048 + 4] == (32'h00FF0F0F ^ seed(10 * 2048 + 4)), "R7 memory",
        mem[10 * 2048 + 4], 32'h00FF0F0F ^ seed(10 * 2048 + 4));
  endtask

  task automatic t_restart();
    clear_log();
    stall = 1;
    wr(3'd2, 32'h83); wr(3'd1, 32'h00ABCDEF);
    geom(0, 0, 1);
    wr(3'd6, 4);
    wr(3'd6, 2);
    wait_idle();
    stall = 0;
    verify("R10 restart", 0, 0, 1, 4, 0, 32'h00ABCDEF);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_replace();
    t_badop();
    t_zero();
    t_retain();
    t_xor();
    t_keep();
    t_restart();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule